// File: doc/BRIEF.md
# Credit-Based Bandwidth Regulator

This block sits on the command path of a single interconnect master port and limits the bandwidth the master can use. It holds a signed credit balance. Every grant period a programmed grant is added to the balance, and every command that is accepted takes one credit away. The balance is compared with three signed thresholds, which divide it into four health levels (0 = most in debt, 3 = healthy).

Each health level supplies a request priority and a priority level, which are attached to outgoing commands. Levels 0 to 2 can also hold back new commands by dropping the ready signal. When the regulator is switched off, commands pass through with their own attributes and are never held.

Configuration is written through a small write port:

| Address | Contents |
|---|---|
| 0 | Bit 0 is the enable. |
| 1 | Period, in bits [PW-1:0]. |
| 2 | Grant. |
| 3 | High threshold. |
| 4 | Middle threshold. |
| 5 | Low threshold. |
| 8+n | Level n: bits [1:0] request priority, bits [3:2] priority level, bit 4 stall. |

Top module: `qcr_top`

## Requirements
- R1: After reset the regulator is off, `cmd_ready_o` is 1 and the command attributes pass through unchanged. The credit balance, the timer, the level register and all configuration reset to 0.
- R2: While the enable bit is 0, `cmd_ready_o` is 1, `cmd_prio_o` equals `cmd_prio_i`, `cmd_lvl_o` equals `cmd_lvl_i`, and the credit balance does not change.
- R3: A write to the grant register (address 2) whose bit 15 is set stores 0x7FFF. Any other value is stored as written.
- R4: Writes to the period, grant and threshold registers (addresses 1 to 5) are ignored while the enable bit is 1. Writes to the enable bit and to the level registers always take effect, one edge after the write.
- R5: On the first clock edge at which the enable bit reads 1 after having read 0, the credit balance is loaded with the grant and the period timer is cleared. That edge ignores both refill and commands.
- R6: While enabled with a period P other than 0, the grant is added on every P-th edge after the load edge. With P = 0 the balance is never refilled.
- R7: Each accepted command (`cmd_valid_i` and `cmd_ready_o` both 1) subtracts one credit. On an edge where both a refill and a command occur, the grant minus one is applied.
- R8: The credit balance saturates at +0x7FFF and at -0x8000; it never wraps.
- R9: The health level is chosen by signed comparison of the balance with the thresholds:
  - balance ≥ high gives level 3;
  - otherwise balance ≥ middle gives level 2;
  - otherwise balance ≥ low gives level 1;
  - otherwise level 0.
- R10: The level is registered: it reflects the balance as it stood before the previous edge. While enabled, `cmd_prio_o` and `cmd_lvl_o` carry the request priority and the priority level of the current level.
- R11: While enabled, `cmd_ready_o` is 0 exactly when the current level is 0, 1 or 2 and its stall bit is set. The stall bit of level 3 is discarded on write, so level 3 never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | 16 | Configuration write data |
| cmd_valid_i | input | 1 | Master presents a command |
| cmd_ready_o | output | 1 | Command may be accepted this cycle |
| cmd_prio_i | input | 2 | Native request priority of the command |
| cmd_lvl_i | input | 2 | Native priority level of the command |
| cmd_prio_o | output | 2 | Request priority forwarded downstream |
| cmd_lvl_o | output | 2 | Priority level forwarded downstream |

## Verification
- **Configuration writes.** A write lands at the edge where it is presented. An enable change reaches the credit logic one edge after the write.
- **Credit balance and level.** The balance moves at the edge that sees the command or the refill. The level register follows the balance one edge later.
- **Command outputs.** `cmd_ready_o` and the forwarded priorities are combinational from that level register and from the command inputs.
- **How the bench checks.** The bench drives its inputs just after a falling edge and compares all three outputs a moment later. It then advances a cycle-exact arithmetic model at the rising edge, using the same register-by-register delays. Every output comparison therefore refers to the model state that the design has at that point.

// File: rtl/qcr_pkg.sv
package qcr_pkg;
  localparam int unsigned NLVL = 4;
  localparam int unsigned AW   = 4;

  localparam logic [AW-1:0] A_CTRL    = 4'd0;
  localparam logic [AW-1:0] A_PERIOD  = 4'd1;
  localparam logic [AW-1:0] A_GRANT   = 4'd2;
  localparam logic [AW-1:0] A_THR_HI  = 4'd3;
  localparam logic [AW-1:0] A_THR_MID = 4'd4;
  localparam logic [AW-1:0] A_THR_LO  = 4'd5;

  typedef struct packed {
    logic       stall;
    logic [1:0] plvl;
    logic [1:0] rprio;
  } lvl_cfg_t;
endpackage

// File: rtl/qcr_cfg.sv
module qcr_cfg
  import qcr_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [CW-1:0]        wdata_i,
  output logic                 en_o,
  output logic [PW-1:0]        period_o,
  output logic [CW-1:0]        grant_o,
  output logic signed [CW-1:0] thr_hi_o,
  output logic signed [CW-1:0] thr_mid_o,
  output logic signed [CW-1:0] thr_lo_o,
  output lvl_cfg_t [NLVL-1:0]  lvl_cfg_o
);
  localparam logic [CW-1:0] GMAX = {1'b0, {(CW-1){1'b1}}};

  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      period_o  <= '0;
      grant_o   <= '0;
      thr_hi_o  <= '0;
      thr_mid_o <= '0;
      thr_lo_o  <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) begin
        en_q <= wdata_i[0];
      end else if (!en_q) begin
        // Timing registers are locked while regulating
        case (addr_i)
          A_PERIOD:  period_o  <= wdata_i[PW-1:0];
          A_GRANT:   grant_o   <= wdata_i[CW-1] ? GMAX : wdata_i;
          A_THR_HI:  thr_hi_o  <= wdata_i;
          A_THR_MID: thr_mid_o <= wdata_i;
          A_THR_LO:  thr_lo_o  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign en_o = en_q;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    lvl_cfg_t r_q;
    logic     hit;

    assign hit = we_i && addr_i == {2'b10, 2'(g)};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= '0;
      end else if (hit) begin
        r_q.rprio <= wdata_i[1:0];
        r_q.plvl  <= wdata_i[3:2];
        // Top level never stalls
        r_q.stall <= (g == NLVL - 1) ? 1'b0 : wdata_i[4];
      end
    end

    assign lvl_cfg_o[g] = r_q;
  end

  p_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && we_i && addr_i == A_PERIOD) |=> $stable(period_o));

  p_clip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && we_i && addr_i == A_GRANT && wdata_i[CW-1]) |=> (grant_o == GMAX));
endmodule

// File: rtl/qcr_credit.sv
module qcr_credit #(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [PW-1:0]        period_i,
  input  logic [CW-1:0]        grant_i,
  input  logic                 accept_i,
  output logic signed [CW-1:0] credit_o
);
  localparam logic signed [CW:0]   SMAX = {2'b00, {(CW-1){1'b1}}};
  localparam logic signed [CW:0]   SMIN = {2'b11, {(CW-1){1'b0}}};
  localparam logic signed [CW-1:0] CMIN = {1'b1, {(CW-1){1'b0}}};

  logic signed [CW-1:0] credit_q;
  logic [PW-1:0]        tmr_q;
  logic                 en_d_q;
  logic                 refill;
  logic signed [CW:0]   sum;

  assign refill = (period_i != '0) && (tmr_q == period_i - PW'(1));

  always_comb begin
    sum = {credit_q[CW-1], credit_q};
    if (refill)   sum = sum + $signed({1'b0, grant_i});
    if (accept_i) sum = sum - (CW+1)'(1);
    if (sum > SMAX)      sum = SMAX;
    else if (sum < SMIN) sum = SMIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= '0;
      tmr_q    <= '0;
      en_d_q   <= 1'b0;
    end else begin
      en_d_q <= en_i;
      if (en_i && !en_d_q) begin
        credit_q <= $signed(grant_i);
        tmr_q    <= '0;
      end else if (en_i) begin
        credit_q <= sum[CW-1:0];
        tmr_q    <= (refill || period_i == '0) ? '0 : tmr_q + PW'(1);
      end
    end
  end

  assign credit_o = credit_q;

  p_hold_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(credit_q));

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_d_q) |=> (credit_q == $signed($past(grant_i))));

  p_drain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_d_q && accept_i && !refill && credit_q != CMIN)
      |=> (credit_q == $past(credit_q) - CW'(1)));
endmodule

// File: rtl/qcr_level.sv
module qcr_level #(
  parameter int unsigned CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [CW-1:0] credit_i,
  input  logic signed [CW-1:0] thr_hi_i,
  input  logic signed [CW-1:0] thr_mid_i,
  input  logic signed [CW-1:0] thr_lo_i,
  output logic [1:0]           lvl_o
);
  logic [1:0] lvl_d;
  logic [1:0] lvl_q;

  always_comb begin
    if (credit_i >= thr_hi_i)       lvl_d = 2'd3;
    else if (credit_i >= thr_mid_i) lvl_d = 2'd2;
    else if (credit_i >= thr_lo_i)  lvl_d = 2'd1;
    else                            lvl_d = 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 2'd0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;

  p_top_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_i >= thr_hi_i) |=> (lvl_q == 2'd3));

  p_bottom_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_i < thr_lo_i && credit_i < thr_mid_i && credit_i < thr_hi_i)
      |=> (lvl_q == 2'd0));
endmodule

// File: rtl/qcr_top.sv
module qcr_top
  import qcr_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [1:0]    cmd_prio_i,
  input  logic [1:0]    cmd_lvl_i,
  output logic [1:0]    cmd_prio_o,
  output logic [1:0]    cmd_lvl_o
);
  logic                 en;
  logic [PW-1:0]        period;
  logic [CW-1:0]        grant;
  logic signed [CW-1:0] thr_hi;
  logic signed [CW-1:0] thr_mid;
  logic signed [CW-1:0] thr_lo;
  lvl_cfg_t [NLVL-1:0]  lvl_cfg;
  logic signed [CW-1:0] credit;
  logic [1:0]           lvl;
  lvl_cfg_t             cur;
  logic                 accept;

  qcr_cfg #(.CW(CW), .PW(PW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .en_o      (en),
    .period_o  (period),
    .grant_o   (grant),
    .thr_hi_o  (thr_hi),
    .thr_mid_o (thr_mid),
    .thr_lo_o  (thr_lo),
    .lvl_cfg_o (lvl_cfg)
  );

  qcr_credit #(.CW(CW), .PW(PW)) u_credit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .period_i (period),
    .grant_i  (grant),
    .accept_i (accept),
    .credit_o (credit)
  );

  qcr_level #(.CW(CW)) u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .credit_i  (credit),
    .thr_hi_i  (thr_hi),
    .thr_mid_i (thr_mid),
    .thr_lo_i  (thr_lo),
    .lvl_o     (lvl)
  );

  assign cur         = lvl_cfg[lvl];
  assign cmd_ready_o = !en || !cur.stall;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign cmd_prio_o  = en ? cur.rprio : cmd_prio_i;
  assign cmd_lvl_o   = en ? cur.plvl  : cmd_lvl_i;

  p_top_no_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl == 2'd3) |-> cmd_ready_o);
endmodule

// File: tb/qcr_top_test.sv
module qcr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_prio_in = '0;
  logic [1:0]  cmd_lvl_in = '0;
  logic [1:0]  cmd_prio_out;
  logic [1:0]  cmd_lvl_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cyc = 0;
  string tag = "R1";

  // Cycle-exact model of the requirements
  bit       m_en = 0, m_en_d = 0;
  int       m_per = 0, m_grant = 0, m_hi = 0, m_mid = 0, m_lo = 0;
  int       m_cr = 0, m_tmr = 0, m_lvl = 0;
  bit [3:0] m_lim = '0;
  int       m_rp [4] = '{0, 0, 0, 0};
  int       m_pl [4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  qcr_top uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready),
    .cmd_prio_i  (cmd_prio_in),
    .cmd_lvl_i   (cmd_lvl_in),
    .cmd_prio_o  (cmd_prio_out),
    .cmd_lvl_o   (cmd_lvl_out)
  );

  function automatic int map_lvl(int c);
    if (c >= m_hi)  return 3;
    if (c >= m_mid) return 2;
    if (c >= m_lo)  return 1;
    return 0;
  endfunction

  function automatic int s16(logic [15:0] d);
    return int'($signed(d));
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic check_out(input bit acc_exp);
    int er, ep, el;
    er = acc_exp;
    ep = m_en ? m_rp[m_lvl] : int'(cmd_prio_in);
    el = m_en ? m_pl[m_lvl] : int'(cmd_lvl_in);
    total++;
    if (int'(cmd_ready) != er || int'(cmd_prio_out) != ep || int'(cmd_lvl_out) != el) begin
      bad++;
      $display("FAIL %s cyc=%0d ready/prio/lvl act=%0d/%0d/%0d exp=%0d/%0d/%0d",
               tag, cyc, cmd_ready, cmd_prio_out, cmd_lvl_out, er, ep, el);
    end
  endtask

  task automatic step(input bit v, input bit we, input logic [3:0] a, input logic [15:0] d);
    bit rdy, acc, refill;
    int nl;
    @(negedge clk);
    cmd_valid   = v;
    cmd_prio_in = cyc[1:0];
    cmd_lvl_in  = cyc[3:2];
    cfg_we      = we;
    cfg_addr    = a;
    cfg_wdata   = d;
    #1;
    rdy = !m_en || !m_lim[m_lvl];
    check_out(rdy);
    acc = v && rdy;
    @(posedge clk);
    cyc++;
    nl = map_lvl(m_cr);
    if (m_en && !m_en_d) begin
      m_cr  = m_grant;
      m_tmr = 0;
    end else if (m_en) begin
      refill = (m_per != 0) && (m_tmr == m_per - 1);
      if (refill) m_cr = m_cr + m_grant;
      if (acc)    m_cr = m_cr - 1;
      if (m_cr > 32767)  m_cr = 32767;
      if (m_cr < -32768) m_cr = -32768;
      m_tmr = (refill || m_per == 0) ? 0 : m_tmr + 1;
    end
    if (we) begin
      if (a == 4'd0) m_en = d[0];
      else if (a[3]) begin
        m_rp[a[1:0]] = int'(d[1:0]);
        m_pl[a[1:0]] = int'(d[3:2]);
        if (a[1:0] != 2'd3) m_lim[a[1:0]] = d[4];
      end else if (!m_en_d_guard()) begin
        case (a)
          4'd1: m_per = int'(d[9:0]);
          4'd2: m_grant = d[15] ? 32767 : int'(d);
          4'd3: m_hi  = s16(d);
          4'd4: m_mid = s16(d);
          4'd5: m_lo  = s16(d);
          default: ;
        endcase
      end
    end
    m_en_d = m_en_q_old;
    m_lvl = nl;
  endtask

  // Enable value as seen by the design at this edge (before the write)
  bit m_en_q_old = 0;
  function automatic bit m_en_d_guard();
    return m_en_q_old;
  endfunction
  always @(negedge clk) m_en_q_old = m_en;

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic idle(input int n, input int vmode);
    for (int i = 0; i < n; i++) begin
      bit v;
      case (vmode)
        0: v = 0;
        1: v = 1;
        default: v = (i % 3) != 0;
      endcase
      step(v, 1'b0, 4'd0, 16'd0);
    end
  endtask

  task automatic setup(input int per, input int grant, input int hi, input int mid, input int lo);
    wr(4'd0, 16'd0);
    wr(4'd1, 16'(per));
    wr(4'd2, 16'(grant));
    wr(4'd3, 16'(hi));
    wr(4'd4, 16'(mid));
    wr(4'd5, 16'(lo));
    wr(4'd0, 16'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    tag = "R1";
    cmd_prio_in = 2'd2;
    cmd_lvl_in  = 2'd1;
    #1;
    check_out(1'b1);
    idle(3, 1);

    // R2: bypass passes all attribute combinations
    tag = "R2";
    idle(20, 1);

    // Level map: level n -> prio n, plvl 3-n; stall on level 0; level 3 stall bit dropped (R11)
    tag = "R11";
    wr(4'd8,  16'h001C);
    wr(4'd9,  16'h0009);
    wr(4'd10, 16'h0006);
    wr(4'd11, 16'h0013);

    // R5 R6 R7 R9 R10: drain to stall, then refill
    tag = "R7";
    setup(4, 3, 0, 16'hFFFE, 16'hFFFD);
    idle(60, 1);
    tag = "R10";
    idle(40, 2);
    tag = "R6";
    idle(30, 0);

    // R4: threshold, grant and period writes ignored while enabled
    tag = "R4";
    wr(4'd3, 16'h7FFF);
    wr(4'd2, 16'd0);
    wr(4'd1, 16'd1);
    idle(30, 1);

    // R11: stall on levels 1 and 2 as well
    tag = "R11";
    wr(4'd9,  16'h0019);
    wr(4'd10, 16'h0016);
    idle(30, 1);
    wr(4'd9,  16'h0009);
    wr(4'd10, 16'h0006);

    // R9: sweep periods and grants
    tag = "R9";
    for (int p = 0; p < 6; p++) begin
      for (int g = 0; g < 4; g++) begin
        setup(p, g, 1, 16'hFFFF, 16'hFFFD);
        idle(30, 2);
      end
    end

    // R3: grant clipping, visible as level 3 at a high threshold of 0x7FFF
    tag = "R3";
    setup(0, 16'h9000, 16'h7FFF, 0, 16'hFFFF);
    idle(6, 0);

    // R8: positive saturation must not wrap
    tag = "R8";
    setup(1, 16'h7FFF, 16'h7FFF, 0, 16'hFFFF);
    idle(10, 0);

    // R8: negative saturation, no stalls, mid/lo at the minimum
    wr(4'd8, 16'h0000);
    setup(0, 0, 0, 16'h8000, 16'h8000);
    idle(32800, 1);
    idle(5, 1);

    // R2: disable again, credit frozen, attributes pass through
    tag = "R2";
    wr(4'd0, 16'd0);
    idle(10, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule